// File: doc/BRIEF.md
# Serial EEPROM Write-Protect Controller

This block is the slave side of a two-wire serial memory. It oversamples the clock and data lines with a faster system clock, finds start and stop conditions, and takes in a device-select byte, a word address and data bytes. It acknowledges each byte by pulling the data line low. Written bytes collect in a 16-entry page buffer. The stop condition that closes a write starts an internal programming interval of fixed length, counted in system clock cycles. During that interval the buffered page is copied into a 1024-byte register-array memory. A single-byte random read returns a stored byte.

A write-protect input can stop a write. It is watched from the clock rise that captures the last bit of the first data byte until programming ends. If it is high at any point before the stop condition, the write is dropped and memory keeps its contents. If it goes high while programming is under way, programming stops at once. The byte being programmed at that moment is then undefined. While programming runs, the device-select byte is not acknowledged, so a master can poll for completion.

Top module: `eewp_ctrl`

## Requirements
- R1: A device-select byte with bits [7:4] equal to 1010 is acknowledged (data line held low during the ninth clock) when no programming is running. Any other code is not acknowledged. Bit 0 selects read (1) or write (0). Bits [2:1] give word address bits 9:8. Bit 3 is ignored.
- R2: Data-line bits are taken on the rising edge of the clock line. The slave changes what it drives on the data line only while the clock line is low.
- R3: After a write transaction with at least one data byte and a stop condition, every data byte is stored at its address ({select bits [2:1], word address}) once programming ends.
- R4: Within one write, the low four address bits advance after each data byte and wrap inside the 16-byte page. The upper six bits do not change.
- R5: For a fixed number of system clock cycles (TWR) after the stop condition that launches programming, device-select bytes are not acknowledged. After that, they are acknowledged again.
- R6: If write-protect is high at any time between the rise that captures the last bit of the first data byte and the stop condition, no programming starts and memory is unchanged.
- R7: Write-protect that is high only before that window opens (for example during the word address) has no effect on the write.
- R8: Write-protect going high during programming ends programming on the following cycle. The slave then acknowledges device-select bytes at once.
- R9: A random read (write select, word address, repeated start, read select) returns the stored byte, most significant bit first.
- R10: After reset, the data line is released and no programming is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| wp_i | input | 1 | Write-protect input, high blocks or ends a write |
| sda_low_o | output | 1 | When high, the slave pulls the data line low |

## Verification
The assertions check several rules on every cycle:
- the slave's drive on the data line changes only while the synchronized clock is low;
- memory is written only while programming runs;
- programming never lasts longer than TWR cycles;
- write-protect during programming ends it within one cycle;
- programming never starts from a cancelled transaction.

Other behaviour only the bench scenarios can show, because it needs whole transactions. This covers stored and read-back byte values, page wrap-around, and the difference between write-protect raised before the window and inside it. It also covers acknowledge polling during and after programming.

// File: rtl/eewp_pkg.sv
package eewp_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADDR, ST_WADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK, ST_WAIT
  } eewp_st_e;
  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eewp_sync.sv
module eewp_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/eewp_mem.sv
module eewp_mem #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ram [2**AW];

  always_ff @(posedge clk) begin
    if (we) ram[addr] <= wdata;
    rdata <= ram[addr];
  end
endmodule

// File: rtl/eewp_prog.sv
module eewp_prog #(
  parameter int TWR  = 2000,
  parameter int PAGE = 16,
  localparam int IW = $clog2(PAGE),
  localparam int CW = $clog2(TWR + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            launch,
  input  logic            abort,
  input  logic [PAGE-1:0] valid,
  output logic            busy,
  output logic            wr_en,
  output logic [IW-1:0]   wr_idx
);
  logic [CW-1:0] cnt;
  logic [IW:0]   idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      cnt  <= '0;
      idx  <= '0;
    end else if (busy) begin
      if (abort) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        if (idx != (IW+1)'(PAGE)) idx <= idx + 1'b1;
        if (cnt == CW'(TWR - 1)) busy <= 1'b0;
      end
    end
  end

  assign wr_idx = idx[IW-1:0];
  assign wr_en  = busy && !abort && (idx < (IW+1)'(PAGE)) && valid[idx[IW-1:0]];
endmodule

// File: rtl/eewp_ctrl.sv
module eewp_ctrl #(
  parameter int MEM_BYTES = 1024,  // 512..2048: select byte carries the bits above 8
  parameter int PAGE      = 16,
  parameter int TWR       = 2000,  // must exceed PAGE
  parameter int SYNC      = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_low_o
);
  import eewp_pkg::*;
  localparam int AW  = $clog2(MEM_BYTES);
  localparam int IW  = $clog2(PAGE);
  localparam int HIW = AW - 8;

  logic scl_s, sda_s, wp_s, scl_d, sda_d;
  eewp_sync #(.WIDTH(3), .STAGES(SYNC), .RST_VAL(3'b110)) sync_i (
    .clk(clk), .rst(rst), .d({scl_i, sda_i, wp_i}), .q({scl_s, sda_s, wp_s}));

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

  eewp_st_e        st;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg, rd_sh;
  logic [AW-1:0]   ptr;
  logic [7:0]      pbuf [PAGE];
  logic [PAGE-1:0] valid;
  logic            first_data, win, cancel, is_read, launch;
  logic            busy, mem_we;
  logic [IW-1:0]   wr_idx;
  logic [7:0]      mem_q;
  logic            d0_rise;

  assign d0_rise = scl_rise && (st == ST_WDATA) && first_data && (bitcnt == 4'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; bitcnt <= '0; shreg <= '0; rd_sh <= '0; ptr <= '0;
      valid <= '0; first_data <= 1'b0; win <= 1'b0; cancel <= 1'b0;
      is_read <= 1'b0; launch <= 1'b0; sda_low_o <= 1'b0;
    end else begin
      launch <= 1'b0;
      if (start_c) begin
        st <= ST_DEV; bitcnt <= '0; sda_low_o <= 1'b0; win <= 1'b0;
        if (!busy) valid <= '0;
      end else if (stop_c) begin
        launch <= (st == ST_WDATA || st == ST_WDATA_ACK) && (|valid)
                  && !cancel && !wp_s && !busy;
        st <= ST_IDLE; sda_low_o <= 1'b0; win <= 1'b0;
      end else if (scl_rise) begin
        case (st)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
            if (d0_rise) win <= 1'b1;
          end
          ST_RDATA: begin
            rd_sh  <= {rd_sh[6:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        case (st)
          ST_DEV: if (bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (shreg[7:4] == DEV_CODE && !busy) begin
              sda_low_o <= 1'b1;
              st <= ST_DEV_ACK;
              is_read <= shreg[0];
              ptr[AW-1:8] <= shreg[HIW:1];
            end else begin
              st <= ST_WAIT;
            end
          end
          ST_WADDR: if (bitcnt == 4'd8) begin
            bitcnt <= '0; ptr[7:0] <= shreg; sda_low_o <= 1'b1;
            st <= ST_WADDR_ACK; first_data <= 1'b1; win <= 1'b0; cancel <= 1'b0;
          end
          ST_WDATA: if (bitcnt == 4'd8) begin
            bitcnt <= '0;
            pbuf[ptr[IW-1:0]]  <= shreg;
            valid[ptr[IW-1:0]] <= 1'b1;
            ptr[IW-1:0] <= ptr[IW-1:0] + 1'b1;
            first_data <= 1'b0; sda_low_o <= 1'b1; st <= ST_WDATA_ACK;
          end
          ST_DEV_ACK: begin
            if (is_read) begin
              st <= ST_RDATA; rd_sh <= mem_q; sda_low_o <= ~mem_q[7]; bitcnt <= '0;
            end else begin
              st <= ST_WADDR; sda_low_o <= 1'b0;
            end
          end
          ST_WADDR_ACK, ST_WDATA_ACK: begin
            st <= ST_WDATA; sda_low_o <= 1'b0;
          end
          ST_RDATA: begin
            if (bitcnt == 4'd8) begin
              sda_low_o <= 1'b0; st <= ST_RACK;
            end else begin
              sda_low_o <= ~rd_sh[7];
            end
          end
          ST_RACK: st <= ST_WAIT;
          default: ;
        endcase
      end
      if ((win || d0_rise) && wp_s && !stop_c && !start_c) cancel <= 1'b1;
    end
  end

  eewp_prog #(.TWR(TWR), .PAGE(PAGE)) prog_i (
    .clk(clk), .rst(rst), .launch(launch), .abort(wp_s), .valid(valid),
    .busy(busy), .wr_en(mem_we), .wr_idx(wr_idx));

  logic [AW-1:0] mem_addr;
  assign mem_addr = busy ? {ptr[AW-1:IW], wr_idx} : ptr;

  eewp_mem #(.AW(AW), .DW(8)) mem_i (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(pbuf[wr_idx]), .rdata(mem_q));
endmodule

// File: rtl/eewp_ctrl_chk.sv
module eewp_ctrl_chk #(
  parameter int TWR = 2000,
  localparam int CW = $clog2(TWR + 1)
) (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic sda_low_o,
  input logic busy,
  input logic wp_s,
  input logic mem_we,
  input logic cancel
);
  logic [CW-1:0] busy_len;
  always_ff @(posedge clk) begin
    if (rst || !busy) busy_len <= '0;
    else if (busy_len != CW'(TWR)) busy_len <= busy_len + 1'b1;
  end

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst) !$stable(sda_low_o) |-> !scl_s); // R2
  AST_WRITE_IN_PROG: assert property (@(posedge clk) disable iff (rst) mem_we |-> busy); // R3
  AST_PROG_BOUNDED:  assert property (@(posedge clk) disable iff (rst) busy |-> busy_len < CW'(TWR)); // R5
  AST_NO_CANCELLED_LAUNCH: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> !cancel); // R6
  AST_WP_ABORTS:     assert property (@(posedge clk) disable iff (rst) busy && wp_s |=> !busy); // R8
  AST_RESET_IDLE:    assert property (@(posedge clk) rst |=> !sda_low_o && !busy); // R10
endmodule

bind eewp_ctrl eewp_ctrl_chk #(.TWR(TWR)) chk_i (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_low_o(sda_low_o), .busy(busy),
  .wp_s(wp_s), .mem_we(mem_we), .cancel(cancel));

// File: tb/eewp_ctrl_tb.sv
module eewp_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H   = 20;
  localparam int TWR = 2000;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_low;
  logic sda_line;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_low;

  eewp_ctrl #(.TWR(TWR)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .wp_i(wp), .sda_low_o(sda_low));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(H); scl_m = 1'b1; hold(H); sda_m = 1'b0; hold(H); scl_m = 1'b0; hold(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(H); scl_m = 1'b1; hold(H); sda_m = 1'b1; hold(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hold(H); scl_m = 1'b1; hold(H); scl_m = 1'b0; hold(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; hold(H); scl_m = 1'b1; hold(H/2); ack = !sda_line; hold(H/2);
    scl_m = 1'b0; hold(H);
  endtask

  task automatic recv_byte(output logic [7:0] d);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; hold(H); scl_m = 1'b1; hold(H/2); d = {d[6:0], sda_line}; hold(H/2);
      scl_m = 1'b0; hold(H);
    end
    send_bit(1'b1);
  endtask

  function automatic logic [7:0] sel(input logic [9:0] a, input logic rd);
    return {4'b1010, 1'b0, a[9:8], rd};
  endfunction

  // wp_mode: 0 none, 1 high during word address only, 2 high after first data byte
  task automatic do_write(input logic [9:0] a, input int n, input logic [7:0] d0,
                          input int wp_mode, input string req);
    bit ack;
    bus_start();
    send_byte(sel(a, 1'b0), ack);
    check(ack, req, ack, 1);
    if (wp_mode == 1) wp = 1'b1;
    send_byte(a[7:0], ack);
    check(ack, req, ack, 1);
    if (wp_mode == 1) begin wp = 1'b0; hold(4); end
    for (int k = 0; k < n; k++) begin
      send_byte(d0 + 8'(k), ack);
      check(ack, req, ack, 1);
      if (wp_mode == 2 && k == 0) begin wp = 1'b1; hold(H); wp = 1'b0; hold(4); end
    end
    bus_stop();
  endtask

  task automatic poll(output bit ack);
    bus_start();
    send_byte(sel(10'h0, 1'b0), ack);
    bus_stop();
  endtask

  task automatic do_read(input logic [9:0] a, output logic [7:0] d, output bit ok);
    bit a1, a2, a3;
    bus_start();
    send_byte(sel(a, 1'b0), a1);
    send_byte(a[7:0], a2);
    bus_start();
    send_byte(sel(a, 1'b1), a3);
    recv_byte(d);
    bus_stop();
    ok = a1 && a2 && a3;
  endtask

  task automatic expect_byte(input logic [9:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d; bit ok;
    do_read(a, d, ok);
    check(ok, req, ok, 1);
    check(d == exp, req, d, exp);
  endtask

  task automatic t_reset();
    bit ack;
    check(sda_low == 1'b0, "R10", sda_low, 0);
    poll(ack);
    check(ack, "R10 R1", ack, 1);
  endtask

  task automatic t_bad_code();
    bit ack;
    bus_start();
    send_byte(8'h5A, ack);
    bus_stop();
    check(!ack, "R1", ack, 0);
  endtask

  task automatic t_single_write();
    bit ack;
    do_write(10'h123, 1, 8'hA5, 0, "R3");
    poll(ack);
    check(!ack, "R5 busy", ack, 0);
    hold(TWR);
    poll(ack);
    check(ack, "R5 done", ack, 1);
    expect_byte(10'h123, 8'hA5, "R3 R9 R2");
  endtask

  task automatic t_page_wrap();
    do_write(10'h23E, 3, 8'h11, 0, "R4");
    hold(TWR + 10);
    expect_byte(10'h23E, 8'h11, "R4");
    expect_byte(10'h23F, 8'h12, "R4");
    expect_byte(10'h230, 8'h13, "R4 wrap");
  endtask

  task automatic t_cancel();
    bit ack;
    do_write(10'h040, 1, 8'h55, 0, "R6 setup");
    hold(TWR + 10);
    do_write(10'h040, 2, 8'hAA, 2, "R6");
    poll(ack);
    check(ack, "R6 no prog", ack, 1);
    expect_byte(10'h040, 8'h55, "R6");
    expect_byte(10'h041, 8'h00, "R6");
  endtask

  task automatic t_early_wp();
    bit ack;
    do_write(10'h341, 1, 8'h66, 1, "R7");
    poll(ack);
    check(!ack, "R7 busy", ack, 0);
    hold(TWR);
    expect_byte(10'h341, 8'h66, "R7");
  endtask

  task automatic t_abort();
    bit ack;
    do_write(10'h0F2, 1, 8'h77, 0, "R8");
    hold(100);
    wp = 1'b1; hold(6); wp = 1'b0; hold(4);
    poll(ack);
    check(ack, "R8 ended", ack, 1);
  endtask

  initial begin
    hold(10);
    rst = 1'b0;
    hold(10);
    t_reset();
    t_bad_code();
    t_single_write();
    t_page_wrap();
    t_cancel();
    t_early_wp();
    t_abort();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule